// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block is a purely combinational unit. For each instruction in flight it works out the address of the next instruction to fetch, and the return address that a jump writes back. It takes the current program counter, the two register operands and an immediate that upstream decode has already sign-extended. It also takes a branch-valid bit with its 3-bit condition code, plus one select for a PC-relative jump and one for a register-indirect jump.

Six separate comparators evaluate every branch condition in parallel. A small control module chooses the condition named by the code and applies a fixed priority among the selects. It then hands two strobes to the datapath: redirect, and base-from-register. The datapath forms a single target sum, clears bit 0 of that sum for the register-indirect jump, and chooses between the target and the sequential address.

Top module: `npc_unit`

## Requirements
- R1: With `brValid` high and no jump select, code 3'b000 redirects when `opA == opB` and code 3'b001 redirects when `opA != opB`.
- R2: Code 3'b100 redirects when `opA` is less than `opB` as signed values, and code 3'b101 redirects when it is greater than or equal as signed values.
- R3: Code 3'b110 redirects when `opA` is less than `opB` as unsigned values, and code 3'b111 redirects when it is greater than or equal as unsigned values.
- R4: A redirecting branch gives `nextPc = curPc + immExt`. A branch that does not redirect gives `nextPc = curPc + 4`.
- R5: With `jalrSel` high, `nextPc` is `(opA + immExt)` with bit 0 forced to zero.
- R6: With `jalSel` high and `jalrSel` low, `nextPc = curPc + immExt`.
- R7: `linkPc` equals `curPc + 4` (modulo 2^XLEN) for every input combination.
- R8: With no select asserted, or with `brValid` high and a code of 3'b010 or 3'b011 and no jump, `nextPc = curPc + 4` and `takenOut` is low.
- R9: `takenOut` is high for every jump and for a branch whose condition holds, and is low otherwise.
- R10: When several selects are high together, `jalrSel` wins over `jalSel`, and `jalSel` wins over a conditional branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| curPc | input | XLEN | Address of the current instruction |
| opA | input | XLEN | First register operand (base for the register-indirect jump) |
| opB | input | XLEN | Second register operand |
| immExt | input | XLEN | Sign-extended offset |
| brValid | input | 1 | Conditional branch in flight |
| brFunc | input | 3 | Branch condition code |
| jalSel | input | 1 | PC-relative jump |
| jalrSel | input | 1 | Register-indirect jump |
| nextPc | output | XLEN | Next fetch address |
| linkPc | output | XLEN | Return address, current PC plus 4 |
| takenOut | output | 1 | Control flow leaves the sequential path |

## Verification
A conditional-branch evaluation and a jump target calculation can both be requested in the same cycle, because the branch-valid bit and both jump selects are independent inputs. The bench sweeps all eight combinations of these three bits against every condition code. It uses operand pairs chosen so that each comparator both holds and fails, including signed and unsigned disagreements at the sign boundary. In each case the bench checks that the target and the taken flag come from the highest-priority select, with the register-indirect result carrying bit 0 cleared even when the offset is odd.

// File: rtl/npc_pkg.sv
package npc_pkg;

  // Branch condition codes; the encoding is shared with the decoder.
  localparam logic [2:0] CodeEq  = 3'b000;
  localparam logic [2:0] CodeNe  = 3'b001;
  localparam logic [2:0] CodeLt  = 3'b100;
  localparam logic [2:0] CodeGe  = 3'b101;
  localparam logic [2:0] CodeLtu = 3'b110;
  localparam logic [2:0] CodeGeu = 3'b111;

  // Index of each comparator in the condition vector.
  localparam int CondEq   = 0;
  localparam int CondNe   = 1;
  localparam int CondLt   = 2;
  localparam int CondGe   = 3;
  localparam int CondLtu  = 4;
  localparam int CondGeu  = 5;
  localparam int NumConds = 6;

  // Strobes from control to datapath.
  typedef struct packed {
    logic redirect;     // leave the sequential path
    logic baseFromReg;  // target base is opA, low bit cleared
  } npcStrobe_t;

endpackage

// File: rtl/npc_cmp.sv
module npc_cmp
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]     opA,
  input  logic [XLEN-1:0]     opB,
  output logic [NumConds-1:0] condVec
);

  logic eqRaw;
  logic ltSigned;
  logic ltUnsigned;

  // Independent comparators, one per condition.
  assign eqRaw      = (opA == opB);
  assign ltSigned   = ($signed(opA) < $signed(opB));
  assign ltUnsigned = (opA < opB);

  always_comb begin
    condVec          = '0;
    condVec[CondEq]  = eqRaw;
    condVec[CondNe]  = (opA != opB);
    condVec[CondLt]  = ltSigned;
    condVec[CondGe]  = ($signed(opA) >= $signed(opB));
    condVec[CondLtu] = ltUnsigned;
    condVec[CondGeu] = (opA >= opB);
  end

endmodule

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic [NumConds-1:0] condVec,
  input  logic                brValid,
  input  logic [2:0]          brFunc,
  input  logic                jalSel,
  input  logic                jalrSel,
  output npcStrobe_t          strobe
);

  logic condHit;

  always_comb begin
    unique case (brFunc)
      CodeEq:  condHit = condVec[CondEq];
      CodeNe:  condHit = condVec[CondNe];
      CodeLt:  condHit = condVec[CondLt];
      CodeGe:  condHit = condVec[CondGe];
      CodeLtu: condHit = condVec[CondLtu];
      CodeGeu: condHit = condVec[CondGeu];
      default: condHit = 1'b0;
    endcase
  end

  // Priority: register jump, then PC-relative jump, then branch.
  always_comb begin
    strobe = '0;
    if (jalrSel) begin
      strobe.redirect    = 1'b1;
      strobe.baseFromReg = 1'b1;
    end else if (jalSel) begin
      strobe.redirect    = 1'b1;
    end else if (brValid) begin
      strobe.redirect    = condHit;
    end
  end

endmodule

// File: rtl/npc_dp.sv
module npc_dp
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] immExt,
  input  npcStrobe_t      strobe,
  output logic [XLEN-1:0] nextPc,
  output logic [XLEN-1:0] linkPc
);

  localparam logic [XLEN-1:0] InsnBytes = XLEN'(4);
  localparam logic [XLEN-1:0] LsbClear  = ~XLEN'(1);

  logic [XLEN-1:0] seqPc;
  logic [XLEN-1:0] baseVal;
  logic [XLEN-1:0] sumVal;
  logic [XLEN-1:0] target;

  assign seqPc   = curPc + InsnBytes;
  assign baseVal = strobe.baseFromReg ? opA : curPc;
  assign sumVal  = baseVal + immExt;
  assign target  = strobe.baseFromReg ? (sumVal & LsbClear) : sumVal;
  assign nextPc  = strobe.redirect ? target : seqPc;
  assign linkPc  = seqPc;

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic [XLEN-1:0] immExt,
  input  logic            brValid,
  input  logic [2:0]      brFunc,
  input  logic            jalSel,
  input  logic            jalrSel,
  output logic [XLEN-1:0] nextPc,
  output logic [XLEN-1:0] linkPc,
  output logic            takenOut
);

  logic [NumConds-1:0] condVec;
  npcStrobe_t          strobe;

  npc_cmp #(.XLEN(XLEN)) u_cmp (
    .opA     (opA),
    .opB     (opB),
    .condVec (condVec)
  );

  npc_ctrl u_ctrl (
    .condVec (condVec),
    .brValid (brValid),
    .brFunc  (brFunc),
    .jalSel  (jalSel),
    .jalrSel (jalrSel),
    .strobe  (strobe)
  );

  npc_dp #(.XLEN(XLEN)) u_dp (
    .curPc  (curPc),
    .opA    (opA),
    .immExt (immExt),
    .strobe (strobe),
    .nextPc (nextPc),
    .linkPc (linkPc)
  );

  assign takenOut = strobe.redirect;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int XLEN = 32
) (
  input logic [XLEN-1:0] curPc,
  input logic [XLEN-1:0] opA,
  input logic [XLEN-1:0] opB,
  input logic [XLEN-1:0] immExt,
  input logic            brValid,
  input logic [2:0]      brFunc,
  input logic            jalSel,
  input logic            jalrSel,
  input logic [XLEN-1:0] nextPc,
  input logic [XLEN-1:0] linkPc,
  input logic            takenOut
);

  logic known;
  assign known = !$isunknown({curPc, opA, opB, immExt, brValid, brFunc,
                              jalSel, jalrSel, nextPc, linkPc, takenOut});

  always_comb begin
    if (known) begin
      // R7
      link_step_chk: assert (linkPc - curPc == XLEN'(4));
      // R5
      jalr_lsb_chk: assert (!jalrSel || !nextPc[0]);
      // R9
      jump_taken_chk: assert (!(jalSel || jalrSel) || takenOut);
      // R4
      fall_through_chk: assert (takenOut || nextPc == linkPc);
      // R8
      idle_seq_chk: assert (jalSel || jalrSel || brValid || (!takenOut && nextPc == linkPc));
      // R1
      eq_branch_chk: assert (!(brValid && !jalSel && !jalrSel && brFunc == 3'b000)
                             || takenOut == (opA == opB));
    end
  end

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
  .curPc    (curPc),
  .opA      (opA),
  .opB      (opB),
  .immExt   (immExt),
  .brValid  (brValid),
  .brFunc   (brFunc),
  .jalSel   (jalSel),
  .jalrSel  (jalrSel),
  .nextPc   (nextPc),
  .linkPc   (linkPc),
  .takenOut (takenOut)
);

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb;

  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  logic [XLEN-1:0] curPc, opA, opB, immExt;
  logic            brValid, jalSel, jalrSel;
  logic [2:0]      brFunc;
  logic [XLEN-1:0] nextPc, linkPc;
  logic            takenOut;

  int nRun  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  npc_unit #(.XLEN(XLEN)) u_dut (
    .curPc(curPc), .opA(opA), .opB(opB), .immExt(immExt),
    .brValid(brValid), .brFunc(brFunc), .jalSel(jalSel), .jalrSel(jalrSel),
    .nextPc(nextPc), .linkPc(linkPc), .takenOut(takenOut)
  );

  function automatic logic condOf(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      3'b000:  return a == b;
      3'b001:  return a != b;
      3'b100:  return $signed(a) < $signed(b);
      3'b101:  return $signed(a) >= $signed(b);
      3'b110:  return a < b;
      3'b111:  return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tagOf(input logic jr, input logic j, input logic bv, input logic [2:0] f);
    if (jr) return (j || bv) ? "R10" : "R5";
    if (j)  return bv ? "R10" : "R6";
    if (!bv) return "R8";
    case (f)
      3'b000, 3'b001: return "R1";
      3'b100, 3'b101: return "R2";
      3'b110, 3'b111: return "R3";
      default:        return "R8";
    endcase
  endfunction

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic applyCase(input logic [31:0] pc, input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] imm, input logic bv, input logic [2:0] f,
                           input logic j, input logic jr, input string forceTag);
    logic        expTaken;
    logic [31:0] expNext;
    string       tag;
    @(negedge clk);
    curPc = pc; opA = a; opB = b; immExt = imm;
    brValid = bv; brFunc = f; jalSel = j; jalrSel = jr;
    #1;
    expTaken = jr | j | (bv & condOf(f, a, b));
    if (!expTaken)   expNext = pc + 32'd4;
    else if (jr)     expNext = (a + imm) & 32'hFFFF_FFFE;
    else             expNext = pc + imm;
    tag = (forceTag != "") ? forceTag : tagOf(jr, j, bv, f);
    checkVal(tag, nextPc, expNext);
    checkVal("R9", {31'd0, takenOut}, {31'd0, expTaken});
    checkVal("R7", linkPc, pc + 32'd4);
  endtask

  initial begin
    logic [31:0] vals [6];
    logic [31:0] imms [3];
    logic [31:0] pcs  [2];
    vals[0] = 32'h0;        vals[1] = 32'h1;        vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h5;
    imms[0] = 32'h0; imms[1] = 32'hFFFF_FFF8; imms[2] = 32'h7FF;
    pcs[0]  = 32'h100; pcs[1] = 32'hFFFF_FFFC;
    curPc = '0; opA = '0; opB = '0; immExt = '0;
    brValid = 1'b0; brFunc = 3'b000; jalSel = 1'b0; jalrSel = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R8: idle state with all-zero inputs
    applyCase(32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 3'b000, 1'b0, 1'b0, "R8");
    // R4: directed taken and not-taken branch
    applyCase(32'h2000, 32'h9, 32'h9, 32'h40, 1'b1, 3'b000, 1'b0, 1'b0, "R4");
    applyCase(32'h2000, 32'h9, 32'hA, 32'h40, 1'b1, 3'b000, 1'b0, 1'b0, "R4");
    // R5: odd register-indirect target
    applyCase(32'h10, 32'h1001, 32'h0, 32'h2, 1'b0, 3'b000, 1'b0, 1'b1, "R5");
    // R2, R3: sign-boundary disagreement
    applyCase(32'h40, 32'h8000_0000, 32'h1, 32'h20, 1'b1, 3'b100, 1'b0, 1'b0, "R2");
    applyCase(32'h40, 32'h8000_0000, 32'h1, 32'h20, 1'b1, 3'b110, 1'b0, 1'b0, "R3");
    for (int p = 0; p < 2; p++)
      for (int ia = 0; ia < 6; ia++)
        for (int ib = 0; ib < 6; ib++)
          for (int im = 0; im < 3; im++)
            for (int f = 0; f < 8; f++)
              for (int s = 0; s < 8; s++)
                applyCase(pcs[p], vals[ia], vals[ib], imms[im] | {31'd0, im[0]},
                          s[0], 3'(f), s[1], s[2], "");
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule